// File: doc/BRIEF.md
# Two-Operand Sum Seven-Segment Display

This block takes two small unsigned operands and drives four seven-segment digits at once. Two digits echo the operands themselves. The other two digits show their sum in decimal, split into a tens digit and a ones digit. With 3-bit operands, the sum runs from 0 to 14.

The block has no clock and no state. It suits a panel where the operands come straight from switches or from registers elsewhere. Every digit output is an active-low pattern, so a segment lights when its bit is 0. The bit order is a (MSB) down to g (LSB).

The tens digit stays dark for sums below ten. The digit decoder has a default branch that turns all segments off. Any code it cannot display therefore produces a dark digit, never a stale or undefined one.

Top module: `sum_seg_display`

## Requirements
- R1: `seg_opa_o` shows the decimal value of `opa_i` (0 to 7) using the R5 patterns.
- R2: `seg_opb_o` shows the decimal value of `opb_i` (0 to 7) using the R5 patterns.
- R3: `seg_ones_o` shows (`opa_i` + `opb_i`) modulo 10 using the R5 patterns.
- R4: `seg_tens_o` equals 1001111 (digit 1) when `opa_i` + `opb_i` is 10 or more. Otherwise it equals 1111111 (all segments off).
- R5: Digit patterns, written abcdefg from bit 6 to bit 0 and active low:
  - 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100
  - 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100
  - blank=1111111
- R6: Every digit output is always one of the eleven R5 patterns. A code the decoder cannot show falls to its default branch and yields blank.
- R7: The block is purely combinational. All four outputs reflect new operand values within the same cycle in which the operands change, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 3 | First operand, unsigned |
| opb_i | input | 3 | Second operand, unsigned |
| seg_opa_o | output | 7 | Active-low pattern for the first operand |
| seg_opb_o | output | 7 | Active-low pattern for the second operand |
| seg_tens_o | output | 7 | Active-low pattern for the tens digit of the sum |
| seg_ones_o | output | 7 | Active-low pattern for the ones digit of the sum |

## Verification
All four results are due zero cycles after a stimulus, because no register lies between operands and segments. The driver applies each operand pair just after a rising edge and queues the expected patterns. The monitor pops and compares them at the following falling edge, half a period later, when the combinational paths have settled. All 64 operand pairs are covered, including both sides of the ten threshold (9, 10 and 14).

// File: rtl/sum_seg_display.sv
module sum_seg_display #(
  parameter int OPW = 3
) (
  input  logic [OPW-1:0] opa_i,
  input  logic [OPW-1:0] opb_i,
  output logic [6:0]     seg_opa_o,
  output logic [6:0]     seg_opb_o,
  output logic [6:0]     seg_tens_o,
  output logic [6:0]     seg_ones_o
);

  localparam int SUMW = OPW + 1;
  localparam logic [6:0] BLANK = 7'b1111111;

  function automatic logic [6:0] digit_seg(input logic [3:0] d);
    case (d)
      4'd0:    digit_seg = 7'b0000001;
      4'd1:    digit_seg = 7'b1001111;
      4'd2:    digit_seg = 7'b0010010;
      4'd3:    digit_seg = 7'b0000110;
      4'd4:    digit_seg = 7'b1001100;
      4'd5:    digit_seg = 7'b0100100;
      4'd6:    digit_seg = 7'b0100000;
      4'd7:    digit_seg = 7'b0001111;
      4'd8:    digit_seg = 7'b0000000;
      4'd9:    digit_seg = 7'b0000100;
      default: digit_seg = BLANK;
    endcase
  endfunction

  function automatic logic is_legal(input logic [6:0] s);
    is_legal = 1'b0;
    for (int k = 0; k < 10; k++)
      if (s == digit_seg(4'(k))) is_legal = 1'b1;
    if (s == BLANK) is_legal = 1'b1;
  endfunction

  logic [SUMW-1:0] sum;
  logic [3:0]      ones_d;
  logic [3:0]      tens_d;

  assign sum    = SUMW'(opa_i) + SUMW'(opb_i);
  assign ones_d = 4'(sum % SUMW'(10));
  assign tens_d = 4'(sum / SUMW'(10));

  assign seg_opa_o  = digit_seg(4'(opa_i));
  assign seg_opb_o  = digit_seg(4'(opb_i));
  assign seg_ones_o = digit_seg(ones_d);
  assign seg_tens_o = (tens_d == 4'd0) ? BLANK : digit_seg(tens_d);

  always_comb begin
    if (!$isunknown({opa_i, opb_i, seg_opa_o, seg_opb_o, seg_tens_o, seg_ones_o})) begin
      // R4: a dark tens digit goes with a sum below ten
      a_r4_tens_blank_low: assert ((seg_tens_o == BLANK) == ((5'(opa_i) + 5'(opb_i)) < 5'd10));
      // R6: every digit output is one of the legal patterns
      a_r6_legal_opa:  assert (is_legal(seg_opa_o));
      a_r6_legal_opb:  assert (is_legal(seg_opb_o));
      a_r6_legal_tens: assert (is_legal(seg_tens_o));
      a_r6_legal_ones: assert (is_legal(seg_ones_o));
      // R1, R2: operand digits are never dark
      a_r1_opa_lit: assert (seg_opa_o != BLANK);
      a_r2_opb_lit: assert (seg_opb_o != BLANK);
      // R3: the ones digit is never dark
      a_r3_ones_lit: assert (seg_ones_o != BLANK);
    end
  end

endmodule

// File: tb/sum_seg_display_tb.sv
module sum_seg_display_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] opa, opb;
  logic [6:0] s_a, s_b, s_t, s_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sum_seg_display u_dut (
    .opa_i(opa), .opb_i(opb),
    .seg_opa_o(s_a), .seg_opb_o(s_b), .seg_tens_o(s_t), .seg_ones_o(s_o)
  );

  // R5 patterns, active low, abcdefg
  localparam logic [6:0] PAT [10] = '{
    7'b0000001, 7'b1001111, 7'b0010010, 7'b0000110, 7'b1001100,
    7'b0100100, 7'b0100000, 7'b0001111, 7'b0000000, 7'b0000100};
  localparam logic [6:0] DARK = 7'b1111111;

  typedef struct {
    int a, b;
    logic [6:0] ea, eb, et, eo;
  } item_t;
  item_t sb_q[$];

  task automatic check(string req, string what, logic [6:0] act, logic [6:0] exp, int a, int b);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s a=%0d b=%0d actual=%b expected=%b", req, what, a, b, act, exp);
    end
  endtask

  task automatic drive(int a, int b);
    item_t it;
    @(posedge clk);
    #1;
    opa = 3'(a);
    opb = 3'(b);
    it.a = a; it.b = b;
    it.ea = PAT[a];
    it.eb = PAT[b];
    it.eo = PAT[(a + b) % 10];
    it.et = (a + b >= 10) ? PAT[1] : DARK;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check("R1", "opa digit", s_a, it.ea, it.a, it.b);
      check("R2", "opb digit", s_b, it.eb, it.a, it.b);
      check("R3", "ones digit", s_o, it.eo, it.a, it.b);
      check("R4", "tens digit", s_t, it.et, it.a, it.b);
    end
  end

  initial begin
    opa = 3'd0;
    opb = 3'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // idle state: operands zero, tens dark (R4), zeros elsewhere (R5)
    check("R4", "idle tens", s_t, DARK, 0, 0);
    check("R5", "idle ones", s_o, 7'b0000001, 0, 0);
    rst_n = 1'b1;
    // R7: each pair's results are compared half a cycle after it is applied
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        drive(a, b);
    // boundary: sums 9, 10, 14 again in non-sweep order (R3, R4)
    drive(7, 3);
    drive(2, 7);
    drive(7, 7);
    drive(5, 5);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule